// File: doc/BRIEF.md
# DShot frame receiver and decoder

This block sits on the motor-controller side of a DShot link. It takes the single-wire command line and passes it through a two-flop synchronizer. It times the high part of every bit cell in system-clock cycles and rebuilds the 16-bit frame. The frame is then split into an 11-bit command field, a telemetry-request bit and a 4-bit checksum. The receiver recomputes the checksum and reports a mismatch. It also places the command field in one of three categories: disarm, special command or throttle setting. For a throttle setting it gives the throttle level with the offset removed.

Two elaboration-time parameters set the timing: the system clock frequency `CLK_HZ` and the link rate `RATE_KBPS` (150, 300 or 600). From these the block derives the cell length and the one/zero decision point in cycles. A long low stretch on the line marks a frame boundary. Each frame that completes gives a one-cycle valid strobe. A malformed frame gives a one-cycle framing-error pulse instead.

Top module: `dshot_rx`

## Requirements
- R1: While reset is asserted and just after release, `frame_valid` and `framing_error` are 0, and every decoded output (field, telemetry bit, checksum, checksum error, category, level) is 0.
- R2: Bits arrive most significant first. A bit is 1 when its high time is strictly greater than the midpoint of the nominal one and zero high times, counted in cycles (117 cycles at 600 kbit/s and 125 MHz). Otherwise the bit is 0. In the 16-bit word, bits 15..5 are `throttle_field`, bit 4 is `telem_req` and bits 3..0 are `crc_rx`.
- R3: Let v be word bits 15..4. The expected checksum is the low 4 bits of v XOR (v>>4) XOR (v>>8). `crc_error` is 1 exactly when this value differs from `crc_rx`. A frame with a checksum mismatch is still reported with `frame_valid`.
- R4: `category` is 0 (disarm) for field 0, 1 (special command) for fields 1 to 47, and 2 (throttle) for fields 48 to 2047. `throttle_level` is the field minus 48 for category 2, and 0 otherwise.
- R5: `frame_valid` is a one-cycle pulse. It is high in the 4th clock cycle after the input pin's 16th falling edge: two synchronizer stages, one edge-detect stage and one assembly register. The decoded outputs keep their values until the next valid frame.
- R6: A frame is accepted only after the line has been low for at least two cell periods. After each accepted frame such a gap is needed again. Pulses that follow a frame with no gap produce neither `frame_valid` nor `framing_error`.
- R7: A high time longer than one cell period, inside a frame, drops the partial frame and pulses `framing_error` once. The receiver then waits for a gap, and the next frame after that gap is decoded normally.
- R8: A gap that starts before 16 bits have arrived drops the partial frame and pulses `framing_error` once. The gap itself counts as the boundary, so the very next frame is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dshot_in | input | 1 | Raw serial command line |
| frame_valid | output | 1 | One-cycle strobe, decoded outputs updated |
| throttle_field | output | 11 | Raw 11-bit command field |
| telem_req | output | 1 | Telemetry-request bit |
| crc_rx | output | 4 | Received checksum nibble |
| crc_error | output | 1 | Received and computed checksums differ |
| category | output | 2 | 0 disarm, 1 special command, 2 throttle |
| throttle_level | output | 11 | Field minus 48 for throttle, else 0 |
| framing_error | output | 1 | One-cycle pulse when a partial frame is dropped |

## Verification
The driver notes the clock cycle of each falling edge it puts on the pin. It queues the expected decode of every frame that should be accepted. The monitor samples on the falling clock edge. When it sees `frame_valid`, it checks that exactly 4 cycles have passed since the last driven falling edge, and compares the fields against the head of the queue. Framing-error pulses and valid strobes are counted continuously. After each error or no-gap scenario, the bench waits a full idle gap, well past the 416-cycle boundary detection. Only then does it compare the counts and the held outputs, so every result of the scenario has had time to appear.

// File: rtl/dshot_rx_pkg.sv
package dshot_rx_pkg;

  localparam int unsigned FRAME_BITS = 16;
  localparam int unsigned FIELD_W    = 11;
  localparam int unsigned CRC_W      = 4;
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
  localparam int unsigned CMD_LAST   = 47;
  localparam int unsigned LVL_BASE   = 48;

  typedef enum logic [1:0] {
    CAT_DISARM   = 2'd0,
    CAT_COMMAND  = 2'd1,
    CAT_THROTTLE = 2'd2
  } cat_e;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_IDLE  = 2'd1,
    ST_FRAME = 2'd2
  } rx_state_e;

  // Nominal timings in nanoseconds, per link rate.
  function automatic int unsigned cell_ns(input int unsigned rate_kbps);
    case (rate_kbps)
      150:     return 6670;
      300:     return 3330;
      default: return 1670;
    endcase
  endfunction

  function automatic int unsigned one_hi_ns(input int unsigned rate_kbps);
    case (rate_kbps)
      150:     return 5000;
      300:     return 2500;
      default: return 1250;
    endcase
  endfunction

  function automatic int unsigned zero_hi_ns(input int unsigned rate_kbps);
    case (rate_kbps)
      150:     return 2500;
      300:     return 1250;
      default: return 625;
    endcase
  endfunction

  function automatic int unsigned ns_to_cyc(input longint unsigned clk_hz,
                                            input int unsigned ns);
    longint unsigned prod;
    prod = (clk_hz * longint'(ns)) / 64'd1_000_000_000;
    return prod[31:0];
  endfunction

  // Checksum over the upper 12 bits of the word.
  function automatic logic [CRC_W-1:0] frame_crc(input logic [11:0] v);
    logic [11:0] t;
    t = v ^ (v >> 4) ^ (v >> 8);
    return t[CRC_W-1:0];
  endfunction

  function automatic cat_e classify(input logic [FIELD_W-1:0] f);
    if (f == '0)                          return CAT_DISARM;
    else if (f <= FIELD_W'(CMD_LAST))     return CAT_COMMAND;
    else                                  return CAT_THROTTLE;
  endfunction

  function automatic logic [FIELD_W-1:0] level_of(input logic [FIELD_W-1:0] f);
    if (f >= FIELD_W'(LVL_BASE)) return f - FIELD_W'(LVL_BASE);
    else                         return '0;
  endfunction

endpackage

// File: rtl/dshot_rx_sync.sv
module dshot_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dshot_rx_pulse_timer.sv
module dshot_rx_pulse_timer #(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned CELL_CYC = 208,
  parameter int unsigned GAP_CYC  = 416
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line,
  output logic             rise,
  output logic             fall,
  output logic [CNT_W-1:0] hi_len,
  output logic             too_long,
  output logic             gap_hit
);
  localparam logic [CNT_W-1:0] CELL_L   = CNT_W'(CELL_CYC);
  localparam logic [CNT_W-1:0] HI_SAT   = CNT_W'(CELL_CYC + 1);
  localparam logic [CNT_W-1:0] GAP_L    = CNT_W'(GAP_CYC);
  localparam logic [CNT_W-1:0] GAP_PRE  = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] ONE_L    = CNT_W'(1);

  logic             line_q;
  logic [CNT_W-1:0] hi_cnt;
  logic [CNT_W-1:0] lo_cnt;

  assign rise = line & ~line_q;
  assign fall = ~line & line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      line_q <= line;
      if (line) begin
        if (rise)                hi_cnt <= ONE_L;
        else if (hi_cnt != HI_SAT) hi_cnt <= hi_cnt + ONE_L;
      end else begin
        if (fall)                lo_cnt <= ONE_L;
        else if (lo_cnt != GAP_L) lo_cnt <= lo_cnt + ONE_L;
      end
    end
  end

  assign hi_len   = hi_cnt;
  assign too_long = line & (hi_cnt == CELL_L);
  assign gap_hit  = ~line & ~fall & (lo_cnt == GAP_PRE);
endmodule

// File: rtl/dshot_rx_framer.sv
module dshot_rx_framer
  import dshot_rx_pkg::*;
#(
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned THRESH_CYC = 117
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rise,
  input  logic                  fall,
  input  logic [CNT_W-1:0]      hi_len,
  input  logic                  too_long,
  input  logic                  gap_hit,
  output logic [FRAME_BITS-1:0] word,
  output logic                  word_done,
  output logic                  frm_err,
  output logic                  bit_strobe,
  output logic [IDX_W-1:0]      bit_idx
);
  localparam logic [CNT_W-1:0] THRESH_L = CNT_W'(THRESH_CYC);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  rx_state_e state;
  logic      bit_val;

  assign bit_val    = hi_len > THRESH_L;
  assign bit_strobe = (state == ST_FRAME) & fall & ~too_long & ~gap_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_HUNT;
      word      <= '0;
      bit_idx   <= '0;
      word_done <= 1'b0;
      frm_err   <= 1'b0;
    end else begin
      word_done <= 1'b0;
      frm_err   <= 1'b0;
      case (state)
        ST_HUNT: begin
          if (gap_hit) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (rise) begin
            state   <= ST_FRAME;
            bit_idx <= '0;
          end
        end
        ST_FRAME: begin
          if (too_long) begin
            frm_err <= 1'b1;
            state   <= ST_HUNT;
          end else if (gap_hit) begin
            frm_err <= 1'b1;
            state   <= ST_IDLE;
          end else if (bit_strobe) begin
            word    <= {word[FRAME_BITS-2:0], bit_val};
            bit_idx <= bit_idx + IDX_W'(1);
            if (bit_idx == LAST_IDX) begin
              word_done <= 1'b1;
              state     <= ST_HUNT;
            end
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/dshot_rx_decoder.sv
module dshot_rx_decoder
  import dshot_rx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  word_done,
  input  logic [FRAME_BITS-1:0] word,
  output logic                  valid,
  output logic [FIELD_W-1:0]    field,
  output logic                  telem,
  output logic [CRC_W-1:0]      crc_rx,
  output logic                  crc_err,
  output logic [1:0]            cat,
  output logic [FIELD_W-1:0]    level
);
  logic [FIELD_W-1:0] w_field;
  logic [11:0]        w_cover;

  assign w_field = word[FRAME_BITS-1 -: FIELD_W];
  assign w_cover = word[FRAME_BITS-1:CRC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      field   <= '0;
      telem   <= 1'b0;
      crc_rx  <= '0;
      crc_err <= 1'b0;
      cat     <= CAT_DISARM;
      level   <= '0;
    end else begin
      valid <= word_done;
      if (word_done) begin
        field   <= w_field;
        telem   <= word[CRC_W];
        crc_rx  <= word[CRC_W-1:0];
        crc_err <= frame_crc(w_cover) != word[CRC_W-1:0];
        cat     <= classify(w_field);
        level   <= level_of(w_field);
      end
    end
  end
endmodule

// File: rtl/dshot_rx.sv
module dshot_rx
  import dshot_rx_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 125_000_000,
  parameter int unsigned RATE_KBPS = 600,
  parameter int unsigned GAP_CELLS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dshot_in,
  output logic          frame_valid,
  output logic [10:0]   throttle_field,
  output logic          telem_req,
  output logic [3:0]    crc_rx,
  output logic          crc_error,
  output logic [1:0]    category,
  output logic [10:0]   throttle_level,
  output logic          framing_error
);
  localparam int unsigned CELL_CYC   = ns_to_cyc(longint'(CLK_HZ), cell_ns(RATE_KBPS));
  localparam int unsigned ONE_CYC    = ns_to_cyc(longint'(CLK_HZ), one_hi_ns(RATE_KBPS));
  localparam int unsigned ZERO_CYC   = ns_to_cyc(longint'(CLK_HZ), zero_hi_ns(RATE_KBPS));
  localparam int unsigned THRESH_CYC = (ONE_CYC + ZERO_CYC) / 2;
  localparam int unsigned GAP_CYC    = GAP_CELLS * CELL_CYC;
  localparam int unsigned CNT_W      = $clog2(GAP_CYC + 2);

  logic                  line_s;
  logic                  rise;
  logic                  fall;
  logic [CNT_W-1:0]      hi_len;
  logic                  too_long;
  logic                  gap_hit;
  logic [FRAME_BITS-1:0] word;
  logic                  word_done;
  logic                  bit_strobe;
  logic [IDX_W-1:0]      bit_idx;

  dshot_rx_sync #(.STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (dshot_in),
    .q     (line_s)
  );

  dshot_rx_pulse_timer #(
    .CNT_W    (CNT_W),
    .CELL_CYC (CELL_CYC),
    .GAP_CYC  (GAP_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .line     (line_s),
    .rise     (rise),
    .fall     (fall),
    .hi_len   (hi_len),
    .too_long (too_long),
    .gap_hit  (gap_hit)
  );

  dshot_rx_framer #(
    .CNT_W      (CNT_W),
    .THRESH_CYC (THRESH_CYC)
  ) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise       (rise),
    .fall       (fall),
    .hi_len     (hi_len),
    .too_long   (too_long),
    .gap_hit    (gap_hit),
    .word       (word),
    .word_done  (word_done),
    .frm_err    (framing_error),
    .bit_strobe (bit_strobe),
    .bit_idx    (bit_idx)
  );

  dshot_rx_decoder u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_done (word_done),
    .word      (word),
    .valid     (frame_valid),
    .field     (throttle_field),
    .telem     (telem_req),
    .crc_rx    (crc_rx),
    .crc_err   (crc_error),
    .cat       (category),
    .level     (throttle_level)
  );
endmodule

// File: rtl/dshot_rx_chk.sv
module dshot_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_valid,
  input logic        framing_error,
  input logic [10:0] throttle_field,
  input logic        telem_req,
  input logic [3:0]  crc_rx,
  input logic        crc_error,
  input logic [1:0]  category,
  input logic [10:0] throttle_level,
  input logic        bit_strobe,
  input logic [3:0]  bit_idx,
  input logic        word_done
);
  logic armed;
  logic [3:0] nib_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign nib_sum = throttle_field[10:7] ^ throttle_field[6:3] ^ {throttle_field[2:0], telem_req};

  assert_strobe_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  assert_hold_between_frames_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !frame_valid) |-> ($stable(throttle_field) && $stable(telem_req) &&
      $stable(crc_rx) && $stable(crc_error) && $stable(category) && $stable(throttle_level)));

  assert_last_bit_to_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && bit_idx == 4'd15) |=> ##1 frame_valid);

  assert_done_to_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> frame_valid);

  assert_crc_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (crc_error == (nib_sum != crc_rx)));

  assert_category_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> ((category == 2'd0) == (throttle_field == 11'd0)) &&
                    ((category == 2'd2) == (throttle_field > 11'd47)) &&
                    (category != 2'd3));

  assert_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && category == 2'd2) |-> (throttle_level + 11'd48 == throttle_field));

  assert_error_excludes_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_valid, framing_error}));

  assert_error_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    framing_error |=> !framing_error);
endmodule

bind dshot_rx dshot_rx_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .frame_valid    (frame_valid),
  .framing_error  (framing_error),
  .throttle_field (throttle_field),
  .telem_req      (telem_req),
  .crc_rx         (crc_rx),
  .crc_error      (crc_error),
  .category       (category),
  .throttle_level (throttle_level),
  .bit_strobe     (bit_strobe),
  .bit_idx        (bit_idx),
  .word_done      (word_done)
);

// File: tb/test_dshot_rx.sv
module test_dshot_rx;
  // 125 MHz clock, 600 kbit/s link: nominal counts in cycles
  localparam int CELL    = 208;
  localparam int ONE_HI  = 156;
  localparam int ZERO_HI = 78;
  localparam int IDLE    = 16 * CELL;

  typedef struct {
    logic [10:0] field;
    logic        telem;
    logic [3:0]  crc;
    logic        crc_err;
    logic [1:0]  cat;
    logic [10:0] level;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dshot_in = 1'b0;
  logic frame_valid, telem_req, crc_error, framing_error;
  logic [10:0] throttle_field, throttle_level;
  logic [3:0] crc_rx;
  logic [1:0] category;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int last_fall = 0;
  int n_valid = 0;
  int n_ferr = 0;
  exp_t exp_q[$];
  exp_t mon_e;
  exp_t last_exp;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dshot_rx i_dshot_rx (
    .clk(clk), .rst_n(rst_n), .dshot_in(dshot_in),
    .frame_valid(frame_valid), .throttle_field(throttle_field),
    .telem_req(telem_req), .crc_rx(crc_rx), .crc_error(crc_error),
    .category(category), .throttle_level(throttle_level),
    .framing_error(framing_error)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [3:0] nib_xor(input logic [11:0] v);
    logic [3:0] c = 4'd0;
    for (int k = 0; k < 3; k++) c = c ^ v[4*k +: 4];
    return c;
  endfunction

  function automatic logic [15:0] mk(input int field, input bit telem, input bit corrupt);
    logic [11:0] v = {11'(field), telem};
    logic [3:0]  c = nib_xor(v);
    if (corrupt) c = ~c;
    return {v, c};
  endfunction

  function automatic exp_t model(input logic [15:0] w);
    exp_t e;
    e.field   = w[15:5];
    e.telem   = w[4];
    e.crc     = w[3:0];
    e.crc_err = (nib_xor(w[15:4]) != w[3:0]);
    if (e.field == 0)       e.cat = 2'd0;
    else if (e.field < 48)  e.cat = 2'd1;
    else                    e.cat = 2'd2;
    e.level = (e.cat == 2'd2) ? e.field - 11'd48 : 11'd0;
    return e;
  endfunction

  task automatic drive_bit(input int hi);
    dshot_in = 1'b1;
    repeat (hi) @(negedge clk);
    dshot_in = 1'b0;
    last_fall = cyc;
    repeat (CELL - hi) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w, input int hi1, input int hi0,
                      input int nbits, input bit push);
    if (push) exp_q.push_back(model(w));
    for (int i = 15; i > 15 - nbits; i--) drive_bit(w[i] ? hi1 : hi0);
  endtask

  task automatic frame(input logic [15:0] w);
    send(w, ONE_HI, ZERO_HI, 16, 1'b1);
    repeat (IDLE) @(negedge clk);
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && frame_valid) begin
      n_valid++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R6", "unexpected frame_valid", 1, 0);
      end else begin
        mon_e = exp_q.pop_front();
        last_exp = mon_e;
        check(cyc - last_fall == 4, "R5", "latency from last falling edge", cyc - last_fall, 4);
        check(throttle_field == mon_e.field, "R2", "throttle_field", throttle_field, mon_e.field);
        check(telem_req == mon_e.telem, "R2", "telem_req", telem_req, mon_e.telem);
        check(crc_rx == mon_e.crc, "R2", "crc_rx", crc_rx, mon_e.crc);
        check(crc_error == mon_e.crc_err, "R3", "crc_error", crc_error, mon_e.crc_err);
        check(category == mon_e.cat, "R4", "category", category, mon_e.cat);
        check(throttle_level == mon_e.level, "R4", "throttle_level", throttle_level, mon_e.level);
      end
    end
    if (rst_n && framing_error) n_ferr++;
  end

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run did not finish", cyc, 190000);
    summary();
  end

  initial begin
    int v0, e0;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(frame_valid == 0 && framing_error == 0, "R1", "strobes in reset",
          {frame_valid, framing_error}, 0);
    check(throttle_field == 0 && throttle_level == 0 && crc_rx == 0 && category == 0
          && telem_req == 0 && crc_error == 0, "R1", "outputs in reset", throttle_field, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(frame_valid == 0 && throttle_field == 0, "R1", "outputs after release", frame_valid, 0);
    repeat (IDLE) @(negedge clk);

    // R4 categories and boundaries, R2 field split, R3 good checksums
    frame(mk(0, 1'b0, 1'b0));
    frame(mk(1, 1'b0, 1'b0));
    frame(mk(47, 1'b1, 1'b0));
    frame(mk(48, 1'b0, 1'b0));
    frame(mk(2047, 1'b1, 1'b0));
    frame(mk(1000, 1'b0, 1'b0));
    // R3 corrupted checksum still reported
    frame(mk(1048, 1'b0, 1'b1));
    frame(16'hA5A5);

    // R2 decision threshold: 118 cycles high is one, 116 is zero
    send(mk(1365, 1'b1, 1'b0), 118, 116, 16, 1'b1);
    repeat (IDLE) @(negedge clk);

    // R6 back-to-back frame without gap is ignored
    v0 = n_valid; e0 = n_ferr;
    send(mk(300, 1'b0, 1'b0), ONE_HI, ZERO_HI, 16, 1'b1);
    send(mk(900, 1'b1, 1'b0), ONE_HI, ZERO_HI, 16, 1'b0);
    repeat (IDLE) @(negedge clk);
    check(n_valid - v0 == 1, "R6", "valids for no-gap pair", n_valid - v0, 1);
    check(n_ferr - e0 == 0, "R6", "framing errors for no-gap pair", n_ferr - e0, 0);

    // R7 overlong high after partial frame
    v0 = n_valid; e0 = n_ferr;
    send(mk(1500, 1'b0, 1'b0), ONE_HI, ZERO_HI, 5, 1'b0);
    dshot_in = 1'b1;
    repeat (300) @(negedge clk);
    dshot_in = 1'b0;
    repeat (IDLE) @(negedge clk);
    check(n_ferr - e0 == 1, "R7", "framing error pulses", n_ferr - e0, 1);
    check(n_valid - v0 == 0, "R7", "valids for dropped frame", n_valid - v0, 0);
    check(throttle_field == last_exp.field && crc_rx == last_exp.crc, "R5",
          "outputs held after drop", throttle_field, last_exp.field);
    frame(mk(777, 1'b1, 1'b0));

    // R8 gap before 16 bits, then immediate next frame
    v0 = n_valid; e0 = n_ferr;
    send(mk(1234, 1'b1, 1'b0), ONE_HI, ZERO_HI, 10, 1'b0);
    repeat (IDLE) @(negedge clk);
    check(n_ferr - e0 == 1, "R8", "framing error pulses", n_ferr - e0, 1);
    check(n_valid - v0 == 0, "R8", "valids for short frame", n_valid - v0, 0);
    frame(mk(50, 1'b0, 1'b0));
    check(n_valid - v0 == 1, "R8", "frame after short frame decoded", n_valid - v0, 1);

    check(exp_q.size() == 0, "R5", "expected frames left undelivered", exp_q.size(), 0);
    summary();
  end
endmodule